// File: doc/BRIEF.md
# Transmit Underrun Soft-Mute Ramp

This block sits at the end of a transmit sample path, just ahead of the converters. It carries a number of signed sample lanes. There are two channels, and each channel has an in-phase lane and a quadrature lane. While the transmit buffer holds data, each lane's input sample goes straight to the output. When the buffer runs dry, the block does not drop the outputs to zero in a single step, because that step would spread energy across a wide band. Instead it shrinks each lane's last output with an arithmetic right shift on every sample strobe, so the signal fades to zero over a few samples.

The buffer-empty flag arrives earlier than the samples it refers to. It therefore passes through a delay line of a configurable length (12 clocks by default), so that the ramp starts on the sample where the data actually runs out. A small controller with three states decides on each sample strobe whether the lanes load, decay or hold:

- `ST_PASS`: the lanes follow their inputs.
- `ST_RAMP`: the lanes are decaying toward zero.
- `ST_MUTED`: all lanes are at zero.

The transitions happen only on a sample strobe:

- *resume*: any state goes to `ST_PASS` when the delayed flag is low.
- *underrun*: `ST_PASS` goes to `ST_RAMP` when the delayed flag is high.
- *settle*: `ST_RAMP` goes to `ST_MUTED` once every lane is zero.
- *stay*: `ST_MUTED` stays muted while the delayed flag is high.

Reset puts the controller in `ST_MUTED`.

Top module: `tx_underrun_softmute`

## Requirements
- R1: A synchronous active-high `rst` sets every output lane to zero and clears the flag delay line. After reset, a strobe with `fifo_empty` low therefore loads its sample, even if `fifo_empty` was high before reset.
- R2: On a clock edge where `sample_stb` is high and the delayed empty flag is low, each lane of `dout` takes the matching lane of `din`. Lane k occupies bits [16k+15:16k]. Lane 0 is channel 0 I, lane 1 is channel 0 Q, lane 2 is channel 1 I, and lane 3 is channel 1 Q.
- R3: On an edge where `sample_stb` is low, `dout` keeps its value.
- R4: A value of `fifo_empty` sampled at edge k takes effect at edge k+ALIGN_DELAY (12 by default). The delay counts clocks, not strobes.
- R5: On a strobe edge where the delayed empty flag is high, each lane becomes its previous output arithmetically shifted right by DECAY_SHIFT (2 by default), with the sign kept.
- R6: When a decay step would produce -1 (all ones), the lane becomes 0, so negative values also settle at exactly zero.
- R7: Each lane decays from its own previous value, independently of the other lanes.
- R8: When the delayed flag clears, the first strobe loads `din` directly, with no ramp-up.
- R9: Once the lanes have reached zero, they stay at zero for as long as the delayed flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | Sample strobe; lanes update only on edges where it is high |
| fifo_empty | input | 1 | Transmit buffer empty, not yet aligned |
| din | input | 64 | Four signed 16-bit input lanes |
| dout | output | 64 | Four signed 16-bit output lanes |

## Verification
The lanes are exercised with a mix of patterns:

- Full-scale positive and negative values.
- The -1 corner value.
- Unrelated values in each lane.

Together these show whether the shift keeps the sign, whether -1 is forced to zero, and whether one lane leaks into another. The empty flag is raised and lowered around strobe trains that contain idle clocks. This separates delay counted in clocks from delay counted in strobes, and a ramp from a hard cut. Raising the flag before a reset and then releasing it shows whether reset clears the delay line.

// File: rtl/softmute_pkg.sv
package softmute_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_MUTED = 2'd0,
        ST_PASS  = 2'd1,
        ST_RAMP  = 2'd2
    } mute_state_t;

    // Per-lane update command
    typedef enum logic [1:0] {
        LANE_HOLD  = 2'd0,
        LANE_LOAD  = 2'd1,
        LANE_DECAY = 2'd2
    } lane_cmd_t;

endpackage

// File: rtl/empty_align_delay.sv
module empty_align_delay #(
    parameter int DEPTH = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic empty_in,
    output logic empty_dly
);

    localparam int CNT_W = $clog2(DEPTH + 1) + 1;

    logic [DEPTH-1:0] taps;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) taps <= '0;
                else     taps <= empty_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) taps <= '0;
                else     taps <= {taps[DEPTH-2:0], empty_in};
            end
        end
    endgenerate

    assign empty_dly = taps[DEPTH-1];

    // Window check: counts the clocks since empty_in was last seen high
    logic [CNT_W-1:0] since_hi;

    always_ff @(posedge clk) begin
        if (rst)                         since_hi <= CNT_W'(DEPTH);
        else if (empty_in)               since_hi <= '0;
        else if (since_hi < CNT_W'(DEPTH)) since_hi <= since_hi + 1'b1;
    end

    // R4
    dly_window_chk: assert property (@(posedge clk) disable iff (rst)
        empty_dly |-> (since_hi < CNT_W'(DEPTH)));

endmodule

// File: rtl/lane_decay.sv
module lane_decay
    import softmute_pkg::*;
#(
    parameter int W     = 16,
    parameter int SHIFT = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  lane_cmd_t           cmd,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] held,
    output logic                is_zero
);

    localparam logic signed [W-1:0] NEG_ONE = {W{1'b1}};

    logic signed [W-1:0] shifted;
    logic signed [W-1:0] decayed;

    always_comb begin
        shifted = held >>> SHIFT;
        decayed = (shifted == NEG_ONE) ? '0 : shifted;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            unique case (cmd)
                LANE_LOAD:  held <= din;
                LANE_DECAY: held <= decayed;
                default:    held <= held;
            endcase
        end
    end

    assign is_zero = (held == '0);

    // R6
    no_neg_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == LANE_DECAY) |=> (held != NEG_ONE));

    // R5
    pos_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == LANE_DECAY && !held[W-1]) |=> (!held[W-1] && held <= $past(held)));

    // R5
    neg_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == LANE_DECAY && held[W-1]) |=> (held >= $past(held)));

endmodule

// File: rtl/softmute_ctrl.sv
module softmute_ctrl
    import softmute_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sample_stb,
    input  logic      empty_dly,
    input  logic      all_zero,
    output lane_cmd_t lane_cmd
);

    mute_state_t state;
    mute_state_t state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_MUTED;
        else     state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (sample_stb) begin
            if (!empty_dly) begin
                state_nx = ST_PASS;                  // resume
            end else begin
                unique case (state)
                    ST_PASS:  state_nx = ST_RAMP;    // underrun
                    ST_RAMP:  state_nx = all_zero ? ST_MUTED : ST_RAMP; // settle
                    ST_MUTED: state_nx = ST_MUTED;   // stay
                    default:  state_nx = ST_MUTED;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        lane_cmd = LANE_HOLD;
        if (sample_stb) begin
            if (!empty_dly) begin
                lane_cmd = LANE_LOAD;
            end else begin
                unique case (state)
                    ST_PASS, ST_RAMP: lane_cmd = LANE_DECAY;
                    default:          lane_cmd = LANE_HOLD;
                endcase
            end
        end
    end

    // R9
    muted_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MUTED) |-> all_zero);

endmodule

// File: rtl/tx_underrun_softmute.sv
module tx_underrun_softmute
    import softmute_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int NUM_CH      = 2,
    parameter int ALIGN_DELAY = 12,
    parameter int DECAY_SHIFT = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                sample_stb,
    input  logic                                fifo_empty,
    input  logic [2*NUM_CH*SAMPLE_W-1:0]        din,
    output logic [2*NUM_CH*SAMPLE_W-1:0]        dout
);

    localparam int NUM_LANES = 2 * NUM_CH;

    logic                       empty_dly;
    lane_cmd_t                  lane_cmd;
    logic [NUM_LANES-1:0]       lane_zero;
    logic                       all_zero;

    empty_align_delay #(.DEPTH(ALIGN_DELAY)) u_align (
        .clk       (clk),
        .rst       (rst),
        .empty_in  (fifo_empty),
        .empty_dly (empty_dly)
    );

    softmute_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sample_stb (sample_stb),
        .empty_dly  (empty_dly),
        .all_zero   (all_zero),
        .lane_cmd   (lane_cmd)
    );

    generate
        for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
            logic signed [SAMPLE_W-1:0] lane_out;

            lane_decay #(.W(SAMPLE_W), .SHIFT(DECAY_SHIFT)) u_lane (
                .clk     (clk),
                .rst     (rst),
                .cmd     (lane_cmd),
                .din     (din[k*SAMPLE_W +: SAMPLE_W]),
                .held    (lane_out),
                .is_zero (lane_zero[k])
            );

            assign dout[k*SAMPLE_W +: SAMPLE_W] = lane_out;
        end
    endgenerate

    assign all_zero = &lane_zero;

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> $stable(dout));

    // R2 R8
    load_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && !empty_dly) |=> (dout == $past(din)));

endmodule

// File: tb/tb_tx_underrun_softmute.sv
`timescale 1ns/1ps
module tb_tx_underrun_softmute;

    localparam int W  = 16;
    localparam int NL = 4;
    localparam int D  = 12;
    localparam int SH = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sample_stb = 1'b0;
    logic            fifo_empty = 1'b0;
    logic [NL*W-1:0] din = '0;
    logic [NL*W-1:0] dout;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic              hist [D];
    logic signed [W-1:0] mdl [NL];

    logic [NL*W-1:0] q_exp [$];
    string           q_tag [$];

    always #10 clk = ~clk;

    tx_underrun_softmute #(
        .SAMPLE_W(W), .NUM_CH(2), .ALIGN_DELAY(D), .DECAY_SHIFT(SH)
    ) dut (
        .clk(clk), .rst(rst), .sample_stb(sample_stb),
        .fifo_empty(fifo_empty), .din(din), .dout(dout)
    );

    function automatic logic signed [W-1:0] tb_decay(input logic signed [W-1:0] x);
        logic signed [W-1:0] y;
        y = x >>> SH;
        if (y == -1) y = '0;
        return y;
    endfunction

    function automatic logic [NL*W-1:0] pack_mdl();
        logic [NL*W-1:0] v;
        for (int k = 0; k < NL; k++) v[k*W +: W] = mdl[k];
        return v;
    endfunction

    task automatic check(input string tag, input logic [NL*W-1:0] got, input logic [NL*W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Driver: one call = one clock
    task automatic step(input bit stb, input bit emp, input logic [NL*W-1:0] d, input string tag);
        logic  dly;
        string t;
        @(posedge clk); #4;
        sample_stb = stb;
        fifo_empty = emp;
        din        = d;
        dly = hist[D-1];
        for (int i = D-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = emp;
        if (stb) begin
            for (int k = 0; k < NL; k++)
                mdl[k] = dly ? tb_decay(mdl[k]) : d[k*W +: W];
        end
        t = tag;
        if (t == "") t = !stb ? "R3" : (dly ? "R5" : "R2");
        q_exp.push_back(pack_mdl());
        q_tag.push_back(t);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk); #2;
            if (q_exp.size() > 0) begin
                logic [NL*W-1:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(t, dout, e);
            end
        end
    end

    task automatic drain();
        while (q_exp.size() > 0) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic do_reset();
        drain();
        @(posedge clk); #4;
        rst = 1'b1; sample_stb = 1'b0; din = '0;
        for (int i = 0; i < D; i++) hist[i] = 1'b0;
        for (int k = 0; k < NL; k++) mdl[k] = '0;
        repeat (3) @(posedge clk);
        #4 rst = 1'b0;
        @(posedge clk); #3;
        check("R1", dout, '0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < D; i++) hist[i] = 1'b0;
        for (int k = 0; k < NL; k++) mdl[k] = '0;
        do_reset();

        // Pass-through with idle clocks between strobes
        step(1, 0, 64'h7FFF_8000_0001_FFFF, "R2");
        step(0, 0, 64'h1111_2222_3333_4444, "R3");
        step(1, 0, 64'h1234_ABCD_0F0F_F0F0, "R2");
        step(0, 0, 64'h0000_0000_0000_0000, "R3");
        step(0, 0, 64'hDEAD_BEEF_CAFE_F00D, "R3");
        step(1, 0, 64'h4000_C000_7FFF_FFFF, "R2");

        // Underrun raised: data still passes for D clocks
        for (int i = 0; i < D; i++)
            step((i % 3) != 1, 1, 64'h4000_C000_7FFF_FFFF, "R4");
        // First decay step: the -1 lane clears, and the lanes differ
        step(1, 1, 64'h0BAD_0BAD_0BAD_0BAD, "R6");
        step(1, 1, 64'h0BAD_0BAD_0BAD_0BAD, "R7");
        step(0, 1, 64'h0BAD_0BAD_0BAD_0BAD, "R3");
        for (int i = 0; i < 8; i++) step(1, 1, 64'h5555_5555_5555_5555, "R5");
        for (int i = 0; i < 4; i++) step(1, 1, 64'h5555_5555_5555_5555, "R9");

        // Flag clears: decay continues for D clocks, then a direct load
        for (int i = 0; i < D; i++) step(1, 0, 64'h2222_3333_4444_5555, "R9");
        step(1, 0, 64'h7FFF_7FFF_8000_8000, "R8");
        step(1, 0, 64'hEDCB_0005_FFF0_FFFD, "R2");

        // Negative-value decay chain
        for (int i = 0; i < D; i++) step(i == D-1 ? 1'b0 : 1'b1, 1, 64'hEDCB_0005_FFF0_FFFD, "R4");
        for (int i = 0; i < 10; i++) step(1, 1, 64'h0, "R6");

        // Reset with the flag high clears the delay line
        for (int i = 0; i < D; i++) step(0, 1, 64'h0, "R3");
        do_reset();
        step(1, 0, 64'h0102_0304_0506_0708, "R1");
        step(1, 0, 64'hF00F_0FF0_8001_7FFE, "R1");

        drain();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule